// File: doc/BRIEF.md
# Sector Hamming Check and Single-Bit Repair

This block judges one 512-byte flash sector at a time. It compares the 24-bit Hamming code that was kept in the spare area with the 24-bit code that was computed while the data came off the device. It then reports one of four outcomes: clean, one data bit repaired, code field damaged, or beyond repair. When exactly one data bit is wrong, the block also gives the byte and bit position of that bit.

While the sector is read, its bytes are also written into a local buffer. After the verdict, the block plays the buffer back in order as a byte stream. The faulty bit is inverted on the way out, so a consumer downstream receives repaired data without having to apply the correction itself.

Top module: `hsec_sector_fix`

## Requirements
- R1: After reset `status` is 0, `done` is 0, `out_valid` is 0, and `err_byte` and `err_bit` are 0.
- R2: Each 24-bit code holds byte0 in [7:0], byte1 in [15:8] and byte2 in [23:16]. Before the two codes are compared, each is spread into a 32-bit word: byte0 goes to bits 7:0, the low nibble of byte2 to bits 11:8, byte1 to bits 23:16 and the high nibble of byte2 to bits 27:24. The syndrome is the XOR of the two spread words. A zero syndrome gives status 0 (clean).
- R3: A syndrome with exactly twelve bits set gives status 1 (repaired). `err_bit` is syndrome bits 18:16 and `err_byte` is syndrome bits 27:19, a value from 0 to 511.
- R4: A syndrome with exactly one bit set gives status 2 (code field damaged). For every status other than 1, `err_byte` and `err_bit` read 0.
- R5: Any other nonzero syndrome gives status 3 (beyond repair), except in the case covered by R6.
- R6: If the spread stored code is 0x0FFF0FFF and the computed code is zero, the sector is an erased page and gets status 0. A computed code one bit away from zero does not get this exemption.
- R7: A start that is accepted at a clock edge produces a `done` pulse of exactly one cycle, which becomes visible after the second following edge. The status and indices update at that same edge.
- R8: The status and indices stay unchanged until the next accepted start.
- R9: A start raised while a sector is still being judged, while the verdict is pending, or while the buffer is being replayed, is ignored: no new `done` and no change of status.
- R10: After each verdict the buffer is replayed once, byte 0 first, with one byte per `out_valid` cycle. The only bit that is inverted is bit `err_bit` of byte `err_byte`, and only when the status is 1. For any other status the bytes come out as they were written.
- R11: Bytes presented with `in_valid` are stored at consecutive addresses. The write address wraps to 0 after byte 511, so each new sector starts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sector byte present on `in_data` |
| in_data | input | 8 | Sector byte being read |
| start | input | 1 | Judge the sector with the codes below |
| code_stored | input | 24 | Code taken from the spare area |
| code_calc | input | 24 | Code computed over the data just read |
| done | output | 1 | One-cycle verdict strobe |
| status | output | 2 | 0 clean, 1 repaired, 2 code damaged, 3 beyond repair |
| err_byte | output | 9 | Byte index of the faulty bit |
| err_bit | output | 3 | Bit index of the faulty bit |
| out_valid | output | 1 | Replay byte present on `out_data` |
| out_data | output | 8 | Replayed byte, repaired when status is 1 |

## Verification
The bench builds the block with its default parameters: a sector of 512 bytes and a population-count tree split into groups of eight bits. With a full-size sector the whole 9-bit byte index range can be reached, so repairs at byte 0 and byte 511 are both exercised, along with wrap of the write address across back-to-back sectors. The three-group tree is exercised by syndromes of weight 1, 2, 12, 16 and 23.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

  typedef enum logic [1:0] {
    HS_CLEAN    = 2'd0,
    HS_FIXED    = 2'd1,
    HS_CODE_BAD = 2'd2,
    HS_UNCORR   = 2'd3
  } hsec_status_e;

  localparam int CODE_W      = 24;
  localparam int WORD_W      = 32;
  localparam int DATA_W      = 8;
  localparam int LOC_BYTE_W  = 9;
  localparam int LOC_BIT_W   = 3;
  localparam int LOC_BASE    = 16;
  localparam int FIX_WEIGHT  = 12;
  localparam int BAD_WEIGHT  = 1;
  localparam logic [WORD_W-1:0] BLANK_WORD = 32'h0FFF_0FFF;

  // Spread a 3-byte code into the 32-bit comparison layout.
  function automatic logic [WORD_W-1:0] spread(input logic [CODE_W-1:0] c);
    spread = {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  // Collect the 24 meaningful bits of a spread word.
  function automatic logic [CODE_W-1:0] gather(input logic [WORD_W-1:0] w);
    gather = {w[27:24], w[23:16], w[11:8], w[7:0]};
  endfunction

endpackage

// File: rtl/hsec_popcount.sv
module hsec_popcount #(
  parameter int W  = 24,
  parameter int G  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_bits,
  output logic          out_valid,
  output logic [CW-1:0] out_count
);
  localparam int NG = (W + G - 1) / G;
  localparam int PW = $clog2(G + 1);

  logic [NG*G-1:0]  padded;
  logic [NG*PW-1:0] part_flat;
  logic             v_q;

  always_comb begin
    padded = '0;
    padded[W-1:0] = in_bits;
  end

  for (genvar g = 0; g < NG; g++) begin : g_group
    logic [PW-1:0] part_d, part_q;
    always_comb begin
      part_d = '0;
      for (int b = 0; b < G; b++) part_d = part_d + PW'(padded[g*G+b]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        part_q <= '0;
      else if (in_valid) part_q <= part_d;
    end
    assign part_flat[g*PW +: PW] = part_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= in_valid;
  end

  always_comb begin
    out_count = '0;
    for (int g = 0; g < NG; g++) out_count = out_count + CW'(part_flat[g*PW +: PW]);
  end
  assign out_valid = v_q;

  // R7: the tree answers exactly one cycle after its input
  assert_tree_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

endmodule

// File: rtl/hsec_decide.sv
module hsec_decide import hsec_pkg::*; #(
  parameter int CW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic [CODE_W-1:0]     code_stored,
  input  logic [CODE_W-1:0]     code_calc,
  output logic                  syn_valid,
  output logic [CODE_W-1:0]     syn_bits,
  input  logic                  cnt_valid,
  input  logic [CW-1:0]         cnt,
  output logic                  done,
  output hsec_status_e          status,
  output logic [LOC_BYTE_W-1:0] err_byte,
  output logic [LOC_BIT_W-1:0]  err_bit,
  output logic                  busy
);
  logic [WORD_W-1:0]     syn_q;
  logic                  blank_q, v0_q;
  hsec_status_e          stat_d, stat_q;
  logic [LOC_BYTE_W-1:0] byte_d, byte_q;
  logic [LOC_BIT_W-1:0]  bit_d, bit_q;
  logic                  done_d, done_q;

  // Stage 0: syndrome and erased-page flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_q   <= '0;
      blank_q <= 1'b0;
      v0_q    <= 1'b0;
    end else begin
      v0_q <= accept;
      if (accept) begin
        syn_q   <= spread(code_stored) ^ spread(code_calc);
        blank_q <= (spread(code_stored) == BLANK_WORD) && (code_calc == '0);
      end
    end
  end

  assign syn_valid = v0_q;
  assign syn_bits  = gather(syn_q);

  // Verdict
  always_comb begin
    stat_d = stat_q;
    byte_d = byte_q;
    bit_d  = bit_q;
    done_d = 1'b0;
    if (cnt_valid) begin
      done_d = 1'b1;
      byte_d = '0;
      bit_d  = '0;
      if (syn_q == '0)                  stat_d = HS_CLEAN;
      else if (cnt == CW'(FIX_WEIGHT)) begin
        stat_d = HS_FIXED;
        byte_d = syn_q[LOC_BASE+LOC_BIT_W +: LOC_BYTE_W];
        bit_d  = syn_q[LOC_BASE +: LOC_BIT_W];
      end
      else if (cnt == CW'(BAD_WEIGHT))  stat_d = HS_CODE_BAD;
      else if (blank_q)                 stat_d = HS_CLEAN;
      else                              stat_d = HS_UNCORR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= HS_CLEAN;
      byte_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      byte_q <= byte_d;
      bit_q  <= bit_d;
      done_q <= done_d;
    end
  end

  assign status   = stat_q;
  assign err_byte = byte_q;
  assign err_bit  = bit_q;
  assign done     = done_q;
  assign busy     = v0_q | cnt_valid | done_q;

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_verdict_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(status) && $stable(err_byte) && $stable(err_bit)));

  assert_code_bad_no_loc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status == HS_CODE_BAD) |-> (err_byte == '0 && err_bit == '0));

endmodule

// File: rtl/hsec_replay.sv
module hsec_replay import hsec_pkg::*; #(
  parameter int SECTOR_BYTES = 512,
  parameter int IDX_W        = $clog2(SECTOR_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wr_byte,
  input  logic                  go,
  input  logic                  fix_en,
  input  logic [LOC_BYTE_W-1:0] fix_byte,
  input  logic [LOC_BIT_W-1:0]  fix_bit,
  output logic                  out_valid,
  output logic [DATA_W-1:0]     out_byte,
  output logic                  busy
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SECTOR_BYTES - 1);

  logic [DATA_W-1:0] store [SECTOR_BYTES];
  logic [IDX_W-1:0]  wptr_d, wptr_q, rptr_d, rptr_q;
  logic              act_d, act_q, ov_d, ov_q;
  logic [DATA_W-1:0] ob_d, ob_q, flip;

  always_ff @(posedge clk) begin
    if (wr_en) store[wptr_q] <= wr_byte;
  end

  always_comb begin
    flip = '0;
    if (fix_en && (32'(rptr_q) == 32'(fix_byte))) flip = DATA_W'(1) << fix_bit;
  end

  always_comb begin
    wptr_d = wptr_q;
    if (wr_en) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    act_d  = act_q;
    rptr_d = rptr_q;
    ov_d   = 1'b0;
    ob_d   = ob_q;
    if (go) begin
      act_d  = 1'b1;
      rptr_d = '0;
    end else if (act_q) begin
      ov_d = 1'b1;
      ob_d = store[rptr_q] ^ flip;
      if (rptr_q == LAST) act_d = 1'b0;
      else                rptr_d = rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      act_q  <= 1'b0;
      ov_q   <= 1'b0;
      ob_q   <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      act_q  <= act_d;
      ov_q   <= ov_d;
      ob_q   <= ob_d;
    end
  end

  assign out_valid = ov_q;
  assign out_byte  = ob_q;
  assign busy      = act_q | ov_q;

  // R10: a replay begins only as a consequence of a verdict strobe
  assert_replay_follows_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(go, 2));

endmodule

// File: rtl/hsec_sector_fix.sv
module hsec_sector_fix import hsec_pkg::*; #(
  parameter int SECTOR_BYTES = 512,
  parameter int POP_GROUP    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        start,
  input  logic [23:0] code_stored,
  input  logic [23:0] code_calc,
  output logic        done,
  output logic [1:0]  status,
  output logic [8:0]  err_byte,
  output logic [2:0]  err_bit,
  output logic        out_valid,
  output logic [7:0]  out_data
);
  localparam int CNT_W = $clog2(CODE_W + 1);
  localparam int IDX_W = $clog2(SECTOR_BYTES);

  logic              accept, dec_busy, rp_busy;
  logic              syn_valid, cnt_valid;
  logic [CODE_W-1:0] syn_bits;
  logic [CNT_W-1:0]  cnt;
  hsec_status_e      stat;

  assign accept = start & ~dec_busy & ~rp_busy;

  hsec_decide #(.CW(CNT_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .code_stored(code_stored), .code_calc(code_calc),
    .syn_valid(syn_valid), .syn_bits(syn_bits),
    .cnt_valid(cnt_valid), .cnt(cnt),
    .done(done), .status(stat), .err_byte(err_byte), .err_bit(err_bit),
    .busy(dec_busy)
  );

  hsec_popcount #(.W(CODE_W), .G(POP_GROUP), .CW(CNT_W)) u_pop (
    .clk(clk), .rst_n(rst_n), .in_valid(syn_valid), .in_bits(syn_bits),
    .out_valid(cnt_valid), .out_count(cnt)
  );

  hsec_replay #(.SECTOR_BYTES(SECTOR_BYTES), .IDX_W(IDX_W)) u_replay (
    .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_byte(in_data),
    .go(done), .fix_en(stat == HS_FIXED), .fix_byte(err_byte), .fix_bit(err_bit),
    .out_valid(out_valid), .out_byte(out_data), .busy(rp_busy)
  );

  assign status = stat;

endmodule

// File: tb/hsec_sector_fix_bench.sv
module hsec_sector_fix_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, start;
  logic [7:0]  in_data;
  logic [23:0] code_stored, code_calc;
  logic        done, out_valid;
  logic [1:0]  status;
  logic [8:0]  err_byte;
  logic [2:0]  err_bit;
  logic [7:0]  out_data;

  int checks = 0;
  int fails = 0;
  int done_seen = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q [$];

  always #5 clk = ~clk;

  hsec_sector_fix u_hsec_sector_fix (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .start(start), .code_stored(code_stored), .code_calc(code_calc),
    .done(done), .status(status), .err_byte(err_byte), .err_bit(err_bit),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((i * 13) + (seed * 29) + (i >> 3));
  endfunction

  // Monitor: verdict strobes and the replayed byte stream (R10 R11)
  always @(negedge clk) begin
    if (rst_n && done) done_seen++;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R10", "unexpected replay byte", out_data, -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R10 R11", "replay byte", out_data, e);
      end
    end
  end

  task automatic run_sector(input int seed, input logic [23:0] st, input logic [23:0] ca,
                            input int exp_st, input int exp_byte, input int exp_bit,
                            input string req, input bit poke);
    int d0;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = pat(seed, i);
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 512; i++) begin
      logic [7:0] b;
      b = pat(seed, i);
      if (exp_st == 1 && i == exp_byte) b ^= 8'(1 << exp_bit);
      exp_q.push_back(b);
    end
    d0 = done_seen;
    start = 1'b1; code_stored = st; code_calc = ca;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R7", "done one edge after start", done, 0);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done two edges after start", done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R7", "done three edges after start", done, 1);
    chk(status == 2'(exp_st), req, "status", status, exp_st);
    chk(err_byte == 9'(exp_byte), req, "err_byte", err_byte, exp_byte);
    chk(err_bit == 3'(exp_bit), req, "err_bit", err_bit, exp_bit);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done pulse width", done, 0);
    if (poke) begin
      // R9: start while replay is running must be ignored
      repeat (3) @(negedge clk);
      start = 1'b1; code_stored = 24'h000000; code_calc = 24'h000000;
      @(negedge clk); start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(status == 2'(exp_st), "R8", "status held", status, exp_st);
    chk(err_byte == 9'(exp_byte), "R8", "err_byte held", err_byte, exp_byte);
    chk(done_seen == d0 + 1, poke ? "R9" : "R8", "verdict count", done_seen - d0, 1);
    chk(out_valid == 1'b0, "R10", "replay finished", out_valid, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; start = 1'b0;
    code_stored = '0; code_calc = '0;
    repeat (3) @(negedge clk);
    chk(status == 2'd0, "R1", "reset status", status, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    chk(err_byte == 9'd0 && err_bit == 3'd0, "R1", "reset indices", err_byte, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 matching codes
    run_sector(1, 24'h123456, 24'h123456, 0, 0, 0, "R2", 1'b0);
    // R3 byte 300 bit 5, with a start poked during replay (R9)
    run_sector(2, 24'h9C6E96, 24'h0A0B0C, 1, 300, 5, "R3", 1'b1);
    // R3 last byte, top bit
    run_sector(3, 24'hAAA55A, 24'h5A5A5A, 1, 511, 7, "R3", 1'b0);
    // R3 first byte, bit 0
    run_sector(4, 24'h1E22CC, 24'h112233, 1, 0, 0, "R3", 1'b0);
    // R4 one-bit syndrome in low byte and in byte2 high nibble
    run_sector(5, 24'h123457, 24'h123456, 2, 0, 0, "R4", 1'b0);
    run_sector(6, 24'h923456, 24'h123456, 2, 0, 0, "R4", 1'b0);
    // R5 weight 2 and weight 16
    run_sector(7, 24'h123455, 24'h123456, 3, 0, 0, "R5", 1'b0);
    run_sector(8, 24'h12CBA9, 24'h123456, 3, 0, 0, "R5", 1'b0);
    // R6 erased page, then one bit away from it
    run_sector(9, 24'hFFFFFF, 24'h000000, 0, 0, 0, "R6", 1'b0);
    run_sector(10, 24'hFFFFFF, 24'h000001, 3, 0, 0, "R6", 1'b0);
    finish_run();
  end

endmodule